// File: doc/BRIEF.md
# Rotating Interrupt Poller and Dispatcher

This block watches a bank of interrupt lines and picks, one at a time, which of them is handed to a downstream message sender. Each line has its own settings for trigger mode (edge or level), active polarity and masking. A scan pointer visits one entry per clock and wraps from the last entry to entry 0. It stops on the first entry it finds pending. After each dispatch the pointer resumes just past the entry it sent. A line's index therefore confers no priority, and a line that is always pending cannot lock out the others.

Before an index is handed on, the block asks two external buffers for permission. The handshake runs in a separate bus clock domain: an active-low request goes out, and the grant comes back only after both active-low acknowledges have been sampled low. The index is then presented with a one-cycle valid pulse. No further request is made until the sender returns a done pulse and the handshake has fully released.

The highest-numbered line has a bypass path. When its entry is masked, its active level is copied, one clock later, onto a dedicated active-low output. When its entry is unmasked, it is treated like every other line.

Top module: `rot_irq_dispatch`

## Requirements
- R1: While reset is applied and in the cycle after it, `send_valid` is 0, `hs_req_n` is 1 and `byp_out_n` is 1.
- R2: An entry in edge mode (`cfg_level[i]`=0) dispatches exactly once for each inactive-to-active transition of its line. The pending state is cleared by the `send_done` that follows.
- R3: An entry in level mode (`cfg_level[i]`=1) is dispatched again after each completion for as long as its line stays active. It stops being dispatched once the line goes inactive.
- R4: `cfg_low[i]`=1 makes line i active low: a falling edge in edge mode, a low level in level mode. `cfg_low[i]`=0 makes it active high.
- R5: After entry k is dispatched, the next dispatch is the first pending entry in the order k+1, k+2, …, wrapping from NUM_IRQ-1 to 0. The entry number gives no precedence.
- R6: `send_valid` is a single-cycle pulse that carries `send_idx`. It only occurs while `hs_req_n` is low and after both `hs_ack1_n` and `hs_ack2_n` have been sampled low. With only one of the acknowledges low, nothing is dispatched.
- R7: A masked entry (`cfg_mask[i]`=1) is never dispatched. Edges that arrive while the entry is masked are lost when it is later unmasked.
- R8: While `cfg_mask[NUM_IRQ-1]`=1, `byp_out_n` equals the inverse of that line's active level, one clock later. While it is 0, `byp_out_n` is 1.
- R9: Only one dispatch is outstanding at a time. No new `send_valid` occurs until `send_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, core domain |
| bus_clk | input | 1 | Clock for the buffer handshake |
| bus_rst | input | 1 | Synchronous active-high reset, handshake domain |
| irq_in | input | NUM_IRQ | Raw interrupt lines |
| cfg_level | input | NUM_IRQ | 1 = level mode, 0 = edge mode, per entry |
| cfg_low | input | NUM_IRQ | 1 = active low, 0 = active high, per entry |
| cfg_mask | input | NUM_IRQ | 1 = entry masked |
| hs_req_n | output | 1 | Active-low buffer request |
| hs_ack1_n | input | 1 | First active-low buffer acknowledge |
| hs_ack2_n | input | 1 | Second active-low buffer acknowledge |
| send_valid | output | 1 | One-cycle pulse: `send_idx` is to be sent |
| send_idx | output | $clog2(NUM_IRQ) | Entry index handed to the sender |
| send_done | input | 1 | Pulse from the sender: message finished |
| byp_out_n | output | 1 | Active-low bypass output for the last line |

## Verification
Several properties are checked on every cycle: reset quietness, the single-cycle valid pulse, the rule that the grant only rises after both acknowledges were low, the one-outstanding limit and the bypass output. The order in which pending entries are served can only be shown by the bench's scenarios, which compare each dispatched index against a behavioural model of the rotating pointer. The same holds for wraparound, fairness between a held level line and an edge, polarity handling, and the loss of edges seen while masked.

// File: rtl/rid_pkg.sv
package rid_pkg;
  typedef enum logic [1:0] {
    S_SCAN,
    S_REQ,
    S_WAIT,
    S_REL
  } scan_state_e;
endpackage

// File: rtl/rid_sync2.sv
// Two-flop synchronizer; no reset so it tracks its input during reset.
module rid_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    meta_q <= d;
    stab_q <= meta_q;
  end

  assign q = stab_q;
endmodule

// File: rtl/rid_front.sv
// Polarity, edge capture and candidate generation for every entry.
module rid_front #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_s,
  input  logic [N-1:0]  cfg_level,
  input  logic [N-1:0]  cfg_low,
  input  logic [N-1:0]  cfg_mask,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  cand
);
  logic [N-1:0] active;
  logic [N-1:0] act_q;
  logic [N-1:0] edge_pend_q;

  assign active = irq_s ^ cfg_low;

  // Previous level is not reset: it follows the line during reset, so no
  // false edge appears when reset is released.
  always_ff @(posedge clk) begin
    act_q <= active;
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        edge_pend_q[i] <= 1'b0;
      end else if (cfg_mask[i] || cfg_level[i]) begin
        edge_pend_q[i] <= 1'b0;
      end else if (active[i] && !act_q[i]) begin
        edge_pend_q[i] <= 1'b1;
      end else if (clr_en && (clr_idx == IW'(i))) begin
        edge_pend_q[i] <= 1'b0;
      end
    end

    assign cand[i] = !cfg_mask[i] && (cfg_level[i] ? active[i] : edge_pend_q[i]);
  end
endmodule

// File: rtl/rid_scan.sv
// Rotating pointer: one entry examined per cycle, dispatch sequencing.
module rid_scan
  import rid_pkg::*;
#(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  cand,
  input  logic          grant_s,
  input  logic          send_done,
  output logic          send_valid,
  output logic [IW-1:0] send_idx,
  output logic          hs_start,
  output logic          clr_en,
  output logic [IW-1:0] clr_idx
);
  scan_state_e   state_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] cur_q;
  logic          start_q;
  logic          valid_q;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] v);
    return (v == IW'(N - 1)) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_SCAN;
      ptr_q   <= '0;
      cur_q   <= '0;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        S_SCAN: begin
          if (cand[ptr_q]) begin
            cur_q   <= ptr_q;
            start_q <= 1'b1;
            state_q <= S_REQ;
          end else begin
            ptr_q <= step(ptr_q);
          end
        end
        S_REQ: begin
          if (grant_s) begin
            valid_q <= 1'b1;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (send_done) begin
            start_q <= 1'b0;
            state_q <= S_REL;
          end
        end
        S_REL: begin
          if (!grant_s) begin
            ptr_q   <= step(cur_q);
            state_q <= S_SCAN;
          end
        end
        default: state_q <= S_SCAN;
      endcase
    end
  end

  assign send_valid = valid_q;
  assign send_idx   = cur_q;
  assign hs_start   = start_q;
  assign clr_en     = (state_q == S_WAIT) && send_done;
  assign clr_idx    = cur_q;
endmodule

// File: rtl/rid_hshake.sv
// Bus-clock side of the four-phase buffer handshake.
module rid_hshake (
  input  logic bus_clk,
  input  logic bus_rst,
  input  logic start,
  input  logic ack1_n,
  input  logic ack2_n,
  output logic req_n,
  output logic grant
);
  logic start_s;
  logic ack1_q;
  logic ack2_q;
  logic req_n_q;
  logic grant_q;

  rid_sync2 #(.W(1)) u_start_sync (
    .clk (bus_clk),
    .d   (start),
    .q   (start_s)
  );

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      ack1_q  <= 1'b1;
      ack2_q  <= 1'b1;
      req_n_q <= 1'b1;
      grant_q <= 1'b0;
    end else begin
      ack1_q  <= ack1_n;
      ack2_q  <= ack2_n;
      req_n_q <= !start_s;
      grant_q <= start_s && (grant_q || (!req_n_q && !ack1_q && !ack2_q));
    end
  end

  assign req_n = req_n_q;
  assign grant = grant_q;
endmodule

// File: rtl/rot_irq_dispatch.sv
module rot_irq_dispatch #(
  parameter int NUM_IRQ = 24,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_clk,
  input  logic               bus_rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] cfg_level,
  input  logic [NUM_IRQ-1:0] cfg_low,
  input  logic [NUM_IRQ-1:0] cfg_mask,
  output logic               hs_req_n,
  input  logic               hs_ack1_n,
  input  logic               hs_ack2_n,
  output logic               send_valid,
  output logic [IDX_W-1:0]   send_idx,
  input  logic               send_done,
  output logic               byp_out_n
);
  localparam int LAST = NUM_IRQ - 1;

  logic [NUM_IRQ-1:0] irq_s;
  logic [NUM_IRQ-1:0] cand;
  logic               clr_en;
  logic [IDX_W-1:0]   clr_idx;
  logic               hs_start;
  logic               grant_bus;
  logic               grant_core;
  logic               byp_q;

  rid_sync2 #(.W(NUM_IRQ)) u_irq_sync (
    .clk (clk),
    .d   (irq_in),
    .q   (irq_s)
  );

  rid_front #(.N(NUM_IRQ), .IW(IDX_W)) u_front (
    .clk       (clk),
    .rst       (rst),
    .irq_s     (irq_s),
    .cfg_level (cfg_level),
    .cfg_low   (cfg_low),
    .cfg_mask  (cfg_mask),
    .clr_en    (clr_en),
    .clr_idx   (clr_idx),
    .cand      (cand)
  );

  rid_scan #(.N(NUM_IRQ), .IW(IDX_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .cand       (cand),
    .grant_s    (grant_core),
    .send_done  (send_done),
    .send_valid (send_valid),
    .send_idx   (send_idx),
    .hs_start   (hs_start),
    .clr_en     (clr_en),
    .clr_idx    (clr_idx)
  );

  rid_hshake u_hshake (
    .bus_clk (bus_clk),
    .bus_rst (bus_rst),
    .start   (hs_start),
    .ack1_n  (hs_ack1_n),
    .ack2_n  (hs_ack2_n),
    .req_n   (hs_req_n),
    .grant   (grant_bus)
  );

  rid_sync2 #(.W(1)) u_grant_sync (
    .clk (clk),
    .d   (grant_bus),
    .q   (grant_core)
  );

  // Bypass for the last line while its entry is masked.
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q <= 1'b1;
    end else begin
      byp_q <= cfg_mask[LAST] ? !(irq_in[LAST] ^ cfg_low[LAST]) : 1'b1;
    end
  end

  assign byp_out_n = byp_q;
endmodule

// File: rtl/rot_irq_dispatch_chk.sv
module rot_irq_dispatch_chk (
  input logic clk,
  input logic rst,
  input logic bus_clk,
  input logic bus_rst,
  input logic send_valid,
  input logic send_done,
  input logic hs_req_n,
  input logic hs_ack1_n,
  input logic hs_ack2_n,
  input logic grant_bus,
  input logic byp_out_n,
  input logic irq_last,
  input logic low_last,
  input logic mask_last
);
  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding_q <= 1'b0;
    end else if (send_valid) begin
      outstanding_q <= 1'b1;
    end else if (send_done) begin
      outstanding_q <= 1'b0;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!send_valid && byp_out_n));

  assert_req_idle_in_reset_R1: assert property (@(posedge bus_clk)
    bus_rst |=> hs_req_n);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
    send_valid |=> !send_valid);

  assert_valid_under_req_R6: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> !hs_req_n);

  assert_grant_after_acks_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
    $rose(grant_bus) |-> (!$past(hs_ack1_n) && !$past(hs_ack2_n)));

  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (rst)
    send_valid |-> !outstanding_q);

  assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_last)) |-> (byp_out_n == !($past(irq_last) ^ $past(low_last))));

  assert_bypass_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mask_last)) |-> byp_out_n);
endmodule

bind rot_irq_dispatch rot_irq_dispatch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_clk    (bus_clk),
  .bus_rst    (bus_rst),
  .send_valid (send_valid),
  .send_done  (send_done),
  .hs_req_n   (hs_req_n),
  .hs_ack1_n  (hs_ack1_n),
  .hs_ack2_n  (hs_ack2_n),
  .grant_bus  (grant_bus),
  .byp_out_n  (byp_out_n),
  .irq_last   (irq_in[NUM_IRQ-1]),
  .low_last   (cfg_low[NUM_IRQ-1]),
  .mask_last  (cfg_mask[NUM_IRQ-1])
);

// File: tb/rot_irq_dispatch_bench.sv
module rot_irq_dispatch_bench;
  localparam int N  = 24;
  localparam int IW = 5;
  localparam int DONE_DLY = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  cfg_level = '0;
  logic [N-1:0]  cfg_low = '0;
  logic [N-1:0]  cfg_mask = '0;
  logic          hs_req_n;
  logic          hs_ack1_n = 1'b1;
  logic          hs_ack2_n = 1'b1;
  logic          send_valid;
  logic [IW-1:0] send_idx;
  logic          send_done = 1'b0;
  logic          byp_out_n;

  int total = 0;
  int bad = 0;
  int ack_mode = 0;      // 0 none, 1 both follow request, 2 only first
  int forced_exp = -1;
  int mptr = 0;
  int n_disp = 0;
  int done_cnt = 0;
  bit outstanding = 1'b0;
  bit finished = 1'b0;
  logic [N-1:0] m_edge = '0;
  int lvl_budget [N];

  rot_irq_dispatch #(.NUM_IRQ(N)) u_rot_irq_dispatch (
    .clk        (clk),
    .rst        (rst),
    .bus_clk    (clk),
    .bus_rst    (rst),
    .irq_in     (irq_in),
    .cfg_level  (cfg_level),
    .cfg_low    (cfg_low),
    .cfg_mask   (cfg_mask),
    .hs_req_n   (hs_req_n),
    .hs_ack1_n  (hs_ack1_n),
    .hs_ack2_n  (hs_ack2_n),
    .send_valid (send_valid),
    .send_idx   (send_idx),
    .send_done  (send_done),
    .byp_out_n  (byp_out_n)
  );

  initial forever #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cand_m(input int i);
    if (cfg_mask[i]) return 1'b0;
    if (cfg_level[i]) return irq_in[i] ^ cfg_low[i];
    return m_edge[i];
  endfunction

  function automatic int next_exp();
    for (int k = 0; k < N; k++) begin
      if (cand_m((mptr + k) % N)) return (mptr + k) % N;
    end
    return -1;
  endfunction

  // Reference model and responders, sampled one time unit after each edge.
  initial begin
    for (int i = 0; i < N; i++) lvl_budget[i] = 0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        chk(byp_out_n == (cfg_mask[N-1] ? !(irq_in[N-1] ^ cfg_low[N-1]) : 1'b1),
            "R8 bypass output", byp_out_n, cfg_mask[N-1] ? !(irq_in[N-1] ^ cfg_low[N-1]) : 1);
        send_done = 1'b0;
        if (done_cnt > 0) begin
          done_cnt--;
          if (done_cnt == 0) begin
            send_done = 1'b1;
            outstanding = 1'b0;
          end
        end
        if (send_valid) begin
          int exp;
          n_disp++;
          chk(!outstanding, "R9 dispatch while outstanding", outstanding, 0);
          chk(!hs_req_n && !hs_ack1_n && !hs_ack2_n, "R6 dispatch without request and both acks",
              {hs_req_n, hs_ack1_n, hs_ack2_n}, 0);
          exp = (forced_exp >= 0) ? forced_exp : next_exp();
          forced_exp = -1;
          chk(exp >= 0 && int'(send_idx) == exp, "R5 dispatch order", send_idx, exp);
          if (exp >= 0) begin
            m_edge[exp] = 1'b0;
            mptr = (exp + 1) % N;
            if (lvl_budget[exp] > 0) begin
              lvl_budget[exp]--;
              if (lvl_budget[exp] == 0) irq_in[exp] = cfg_low[exp];
            end
          end
          done_cnt = DONE_DLY;
          outstanding = 1'b1;
        end
        case (ack_mode)
          1: begin hs_ack1_n = hs_req_n; hs_ack2_n = hs_req_n; end
          2: begin hs_ack1_n = hs_req_n; hs_ack2_n = 1'b1; end
          default: begin hs_ack1_n = 1'b1; hs_ack2_n = 1'b1; end
        endcase
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_pulse(input int i);
    @(negedge clk);
    irq_in[i] = !cfg_low[i];
    if (!cfg_mask[i] && !cfg_level[i]) m_edge[i] = 1'b1;
    cycles(3);
    irq_in[i] = cfg_low[i];
    cycles(2);
  endtask

  // Reconfigure an entry under mask so no stray edge or level is seen.
  task automatic cfg_entry(input int i, input bit lvl, input bit low);
    bit keep;
    keep = cfg_mask[i];
    @(negedge clk);
    cfg_mask[i] = 1'b1;
    irq_in[i] = low;
    cycles(4);
    cfg_level[i] = lvl;
    cfg_low[i] = low;
    cycles(4);
    cfg_mask[i] = keep;
  endtask

  task automatic wait_req(input string req);
    int k = 0;
    while (hs_req_n && k < 500) begin
      @(negedge clk);
      k++;
    end
    chk(hs_req_n == 1'b0, req, hs_req_n, 0);
  endtask

  initial begin
    int base;
    cycles(5);
    chk(send_valid == 1'b0, "R1 valid in reset", send_valid, 0);
    chk(hs_req_n == 1'b1, "R1 request in reset", hs_req_n, 1);
    chk(byp_out_n == 1'b1, "R1 bypass in reset", byp_out_n, 1);
    rst = 1'b0;
    cycles(3);
    chk(hs_req_n == 1'b1 && send_valid == 1'b0, "R1 quiet after reset", hs_req_n, 1);

    // R2/R5: edges, wraparound past the last entry
    base = n_disp;
    edge_pulse(20);
    wait_req("R6 request before dispatch");
    forced_exp = 20;
    edge_pulse(2);
    edge_pulse(9);
    edge_pulse(21);
    edge_pulse(23);
    ack_mode = 1;
    cycles(500);
    chk(n_disp - base == 5, "R2 one dispatch per edge", n_disp - base, 5);

    // R3/R5: held level line alternates with an edge (no starvation)
    ack_mode = 0;
    cfg_entry(7, 1'b1, 1'b0);
    base = n_disp;
    @(negedge clk);
    lvl_budget[7] = 2;
    irq_in[7] = 1'b1;
    wait_req("R6 request for level entry");
    forced_exp = 7;
    edge_pulse(3);
    ack_mode = 1;
    cycles(400);
    chk(n_disp - base == 3, "R3 level redispatch then stop", n_disp - base, 3);

    // R4: active-low level and active-low edge
    cfg_entry(10, 1'b1, 1'b1);
    base = n_disp;
    @(negedge clk);
    lvl_budget[10] = 1;
    irq_in[10] = 1'b0;
    cycles(200);
    chk(n_disp - base == 1, "R4 active-low level", n_disp - base, 1);
    cfg_entry(5, 1'b0, 1'b1);
    base = n_disp;
    edge_pulse(5);
    cycles(200);
    chk(n_disp - base == 1, "R4 active-low edge once", n_disp - base, 1);

    // R7: masked edge is lost; masked level never sent until unmasked
    base = n_disp;
    @(negedge clk);
    cfg_mask[12] = 1'b1;
    edge_pulse(12);
    @(negedge clk);
    cfg_mask[12] = 1'b0;
    cycles(150);
    chk(n_disp - base == 0, "R7 masked edge dropped", n_disp - base, 0);
    cfg_entry(14, 1'b1, 1'b0);
    @(negedge clk);
    cfg_mask[14] = 1'b1;
    irq_in[14] = 1'b1;
    cycles(150);
    chk(n_disp - base == 0, "R7 masked level held off", n_disp - base, 0);
    lvl_budget[14] = 1;
    cfg_mask[14] = 1'b0;
    cycles(200);
    chk(n_disp - base == 1, "R7 level sent once unmasked", n_disp - base, 1);

    // R8: bypass of the last line while masked
    base = n_disp;
    @(negedge clk);
    cfg_mask[N-1] = 1'b1;
    for (int t = 0; t < 6; t++) begin
      cycles(7);
      irq_in[N-1] = !irq_in[N-1];
    end
    cycles(7);
    irq_in[N-1] = 1'b0;
    cycles(3);
    chk(byp_out_n == 1'b1, "R8 bypass released at idle", byp_out_n, 1);
    cfg_mask[N-1] = 1'b0;
    cycles(50);
    chk(n_disp - base == 0, "R8 masked last line not dispatched", n_disp - base, 0);

    // R6: a single acknowledge is not enough
    ack_mode = 2;
    base = n_disp;
    edge_pulse(1);
    cycles(150);
    chk(n_disp - base == 0, "R6 one ack blocks dispatch", n_disp - base, 0);
    chk(hs_req_n == 1'b0, "R6 request held while waiting", hs_req_n, 0);
    ack_mode = 1;
    cycles(150);
    chk(n_disp - base == 1, "R6 dispatch after both acks", n_disp - base, 1);
    chk(hs_req_n == 1'b1, "R9 request released after done", hs_req_n, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule